// File: doc/BRIEF.md
# Store-to-Load Forwarding Unit

This block sits between a core's load/store pipeline and a simple byte-addressed backing memory. Stores of 8, 16 or 32 bytes enter a small in-order store buffer. They leave it one at a time, oldest first, when the drain input writes them into memory. Each load is compared with every buffered store. The youngest overlapping store decides the outcome. The load either takes its data straight from that store, or it raises a forwarding-block indication and waits until the conflicting stores have reached memory.

Forwarding is decided per 16-byte half. A same-size, same-address store forwards when its size is 8 or 16 bytes. A 32-byte store can feed a 16-byte load that lies wholly in one of its halves. It cannot feed any load that spans its midpoint, and that includes a 32-byte load at exactly its own address. Every blocked load adds one to a saturating event counter. The counter stays the same however long the load then waits.

All accesses are naturally aligned to their size. Size codes: 0 = 8 bytes, 1 = 16 bytes, 2 = 32 bytes. Data is byte-packed from bit 0 upward: byte j of an access sits at bits 8j+7..8j. Bytes above the access size are zero in a response.

Top module: `sfwd_unit`

## Requirements
- R1: A 16-byte (or 8-byte) load at the same address and size as the youngest overlapping store is forwarded from it: response flagged forwarded, data equal to the store data, no block pulse, counter unchanged.
- R2: A 16-byte load inside either half of a buffered 32-byte store is forwarded. It returns store bytes 0..15 when address bit 4 is 0, and store bytes 16..31 when it is 1.
- R3: A 32-byte load at the address of a buffered 32-byte store is not forwarded. It raises a one-cycle block pulse instead of a response.
- R4: Every other overlap with the youngest overlapping store is blocked. This covers a load larger or smaller than that store, except the 16-in-32 case of R2.
- R5: When several buffered stores overlap a load, only the youngest decides between forwarding and blocking, and a forwarded result carries its data.
- R6: A blocked load gives no response while any overlapping store remains buffered. Once the last one has drained, it responds from memory with the merged bytes of all earlier stores.
- R7: Each blocked load increments the block counter exactly once, however many cycles it waits.
- R8: A load that overlaps no buffered store returns memory data, unflagged as forwarded, and leaves the counter unchanged.
- R9: The buffer holds DEPTH (default 4) stores. Store-ready is low when it is full, and a store offered then is dropped. Draining writes stores to memory oldest first.
- R10: The counter is CNT_W bits (default 32), saturates at its all-ones value, and clears to zero on synchronous reset.
- R11: After reset the buffer is empty, both ready outputs are high, no response or block pulse is present, and memory reads as zero.
- R12: A load is accepted in a cycle when load-ready is high. Its response or block pulse appears two clock edges later. Load-ready and store-ready stay low while the load is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stValid | input | 1 | Store offered |
| stReady | output | 1 | Buffer can take a store (not full, no load outstanding) |
| stAddr | input | ADDR_W | Store byte address, aligned to its size |
| stSize | input | 2 | Store size code |
| stData | input | 256 | Store data, byte-packed from bit 0 |
| drainEn | input | 1 | Write the oldest buffered store to memory |
| ldValid | input | 1 | Load request |
| ldReady | output | 1 | Load request can be accepted |
| ldAddr | input | ADDR_W | Load byte address, aligned to its size |
| ldSize | input | 2 | Load size code |
| ldRespValid | output | 1 | Load response present for one cycle |
| ldRespData | output | 256 | Load data, upper bytes zero |
| ldRespFwd | output | 1 | Response came from a buffered store |
| ldFwdBlock | output | 1 | One-cycle pulse: load blocked from forwarding |
| blockCount | output | CNT_W | Saturating count of blocked loads |

## Verification
A load accepted on one edge is evaluated in the next cycle. Its response or block pulse is registered on the second edge after acceptance. The bench therefore samples both at the falling edge that follows that second edge. A blocked load that sees its last conflicting store leave on a drain edge needs one more evaluation cycle. The bench checks that the response is still absent at the falling edge just after that drain, and present one cycle later. The counter updates on the same edge as the block pulse, so the bench reads it at the same falling edge. The bench also reads it again after extra waiting cycles to confirm that it does not count twice.

// File: rtl/sfwd_pkg.sv
package sfwd_pkg;
  localparam int LINE_BYTES = 32;
  localparam int LINE_BITS  = LINE_BYTES * 8;
  localparam int HALF_BIT   = 4;

  localparam logic [1:0] SZ_8  = 2'd0;
  localparam logic [1:0] SZ_16 = 2'd1;
  localparam logic [1:0] SZ_32 = 2'd2;

  typedef struct packed {
    logic takeReq;
    logic respFwd;
    logic respMem;
    logic countBlock;
    logic pulseBlock;
  } ctrlStrb_t;

  function automatic int nBytes(input logic [1:0] sz);
    return 8 << sz;
  endfunction

  function automatic logic [LINE_BITS-1:0] sizeMask(input logic [1:0] sz);
    logic [LINE_BITS-1:0] m;
    m = '0;
    for (int j = 0; j < LINE_BYTES; j++)
      if (j < nBytes(sz)) m[8*j +: 8] = 8'hFF;
    return m;
  endfunction
endpackage

// File: rtl/sfwd_ctrl.sv
module sfwd_ctrl
  import sfwd_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      ldValid,
  input  logic      hit,
  input  logic      canFwd,
  output logic      ldReady,
  output logic      busy,
  output ctrlStrb_t strb
);
  typedef enum logic {ST_IDLE, ST_BUSY} state_e;
  state_e state;
  logic   seen;

  assign ldReady = (state == ST_IDLE);
  assign busy    = (state == ST_BUSY);

  always_comb begin
    strb = '0;
    if (state == ST_IDLE) begin
      strb.takeReq = ldValid;
    end else if (!hit) begin
      strb.respMem = 1'b1;
    end else if (canFwd) begin
      strb.respFwd = 1'b1;
    end else if (!seen) begin
      strb.countBlock = 1'b1;
      strb.pulseBlock = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      seen  <= 1'b0;
    end else begin
      if (strb.takeReq) state <= ST_BUSY;
      if (strb.respFwd || strb.respMem) begin
        state <= ST_IDLE;
        seen  <= 1'b0;
      end else if (strb.countBlock) begin
        seen <= 1'b1;
      end
    end
  end

  // R7
  single_count_chk: assert property (@(posedge clk) disable iff (rst)
    strb.countBlock |=> !strb.countBlock);

  // R12
  resp_ends_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && (strb.respFwd || strb.respMem)) |=> ldReady);
endmodule

// File: rtl/sfwd_datapath.sv
module sfwd_datapath
  import sfwd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 4,
  parameter int CNT_W  = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 stValid,
  output logic                 stReady,
  input  logic [ADDR_W-1:0]    stAddr,
  input  logic [1:0]           stSize,
  input  logic [LINE_BITS-1:0] stData,
  input  logic                 drainEn,
  input  logic [ADDR_W-1:0]    ldAddr,
  input  logic [1:0]           ldSize,
  input  ctrlStrb_t            strb,
  input  logic                 busyIn,
  output logic                 hit,
  output logic                 canFwd,
  output logic                 respValid,
  output logic [LINE_BITS-1:0] respData,
  output logic                 respFwd,
  output logic                 blockPulse,
  output logic [CNT_W-1:0]     blockCnt
);
  localparam int PTR_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int MEM_BYTES = 1 << ADDR_W;

  logic [ADDR_W-1:0]    entAddr [DEPTH];
  logic [1:0]           entSize [DEPTH];
  logic [LINE_BITS-1:0] entData [DEPTH];
  logic [PTR_W-1:0]     wrPtr, rdPtr;
  logic [PTR_W:0]       count;
  logic [7:0]           mem [MEM_BYTES];

  logic [ADDR_W-1:0] ldAddrQ;
  logic [1:0]        ldSizeQ;

  logic push, pop;
  assign stReady = (count < (PTR_W+1)'(DEPTH)) && !busyIn;
  assign push    = stValid && stReady;
  assign pop     = drainEn && (count != '0);

  // store buffer, in-order
  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) begin
        entAddr[wrPtr] <= stAddr;
        entSize[wrPtr] <= stSize;
        entData[wrPtr] <= stData;
        wrPtr          <= wrPtr + 1'b1;
      end
      if (pop) rdPtr <= rdPtr + 1'b1;
      count <= count + (PTR_W+1)'(push) - (PTR_W+1)'(pop);
    end
  end

  // backing memory
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < MEM_BYTES; b++) mem[b] <= 8'h00;
    end else if (pop) begin
      for (int j = 0; j < LINE_BYTES; j++)
        if (j < nBytes(entSize[rdPtr]))
          mem[entAddr[rdPtr] + ADDR_W'(j)] <= entData[rdPtr][8*j +: 8];
    end
  end

  // captured load request
  always_ff @(posedge clk) begin
    if (rst) begin
      ldAddrQ <= '0;
      ldSizeQ <= SZ_8;
    end else if (strb.takeReq) begin
      ldAddrQ <= ldAddr;
      ldSizeQ <= ldSize;
    end
  end

  // overlap per entry
  logic [DEPTH-1:0] ovl;
  logic [ADDR_W:0]  ldEnd;
  assign ldEnd = {1'b0, ldAddrQ} + (ADDR_W+1)'(nBytes(ldSizeQ));

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    logic [ADDR_W:0] stEnd;
    assign stEnd  = {1'b0, entAddr[i]} + (ADDR_W+1)'(nBytes(entSize[i]));
    assign ovl[i] = ({1'b0, ldAddrQ} < stEnd) && ({1'b0, entAddr[i]} < ldEnd);
  end

  // youngest overlapping entry: walk oldest to youngest, last wins
  logic [PTR_W-1:0] yIdx;
  always_comb begin
    hit  = 1'b0;
    yIdx = rdPtr;
    for (int k = 0; k < DEPTH; k++) begin
      if (((PTR_W+1)'(k) < count) && ovl[rdPtr + PTR_W'(k)]) begin
        hit  = 1'b1;
        yIdx = rdPtr + PTR_W'(k);
      end
    end
  end

  logic [1:0]  ySize;
  logic        sameShape, halfFit;
  assign ySize     = entSize[yIdx];
  assign sameShape = (ySize == ldSizeQ) && (entAddr[yIdx] == ldAddrQ) && (ySize != SZ_32);
  assign halfFit   = (ySize == SZ_32) && (ldSizeQ == SZ_16);
  assign canFwd    = hit && (sameShape || halfFit);

  logic [LINE_BITS-1:0] fwdData, memData;
  always_comb begin
    fwdData = entData[yIdx];
    if (halfFit && ldAddrQ[HALF_BIT]) fwdData = fwdData >> (LINE_BITS/2);
    fwdData = fwdData & sizeMask(ldSizeQ);
  end

  always_comb begin
    memData = '0;
    for (int j = 0; j < LINE_BYTES; j++)
      if (j < nBytes(ldSizeQ)) memData[8*j +: 8] = mem[ldAddrQ + ADDR_W'(j)];
  end

  // response and event counter
  always_ff @(posedge clk) begin
    if (rst) begin
      respValid  <= 1'b0;
      respData   <= '0;
      respFwd    <= 1'b0;
      blockPulse <= 1'b0;
      blockCnt   <= '0;
    end else begin
      respValid  <= strb.respFwd || strb.respMem;
      respFwd    <= strb.respFwd;
      blockPulse <= strb.pulseBlock;
      if (strb.respFwd)      respData <= fwdData;
      else if (strb.respMem) respData <= memData;
      if (strb.countBlock && (blockCnt != {CNT_W{1'b1}}))
        blockCnt <= blockCnt + 1'b1;
    end
  end

  // R9
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (count == (PTR_W+1)'(DEPTH) && !drainEn) |=> (count == (PTR_W+1)'(DEPTH)));

  // R10
  cnt_mono_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (blockCnt >= $past(blockCnt)));

  // R3
  resp_xor_block_chk: assert property (@(posedge clk) disable iff (rst)
    respValid |-> !blockPulse);

  // R12
  resp_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    respValid |-> $past(busyIn));
endmodule

// File: rtl/sfwd_unit.sv
module sfwd_unit
  import sfwd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 4,
  parameter int CNT_W  = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 stValid,
  output logic                 stReady,
  input  logic [ADDR_W-1:0]    stAddr,
  input  logic [1:0]           stSize,
  input  logic [LINE_BITS-1:0] stData,
  input  logic                 drainEn,
  input  logic                 ldValid,
  output logic                 ldReady,
  input  logic [ADDR_W-1:0]    ldAddr,
  input  logic [1:0]           ldSize,
  output logic                 ldRespValid,
  output logic [LINE_BITS-1:0] ldRespData,
  output logic                 ldRespFwd,
  output logic                 ldFwdBlock,
  output logic [CNT_W-1:0]     blockCount
);
  ctrlStrb_t strb;
  logic      hit, canFwd, busy;

  sfwd_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .ldValid (ldValid),
    .hit     (hit),
    .canFwd  (canFwd),
    .ldReady (ldReady),
    .busy    (busy),
    .strb    (strb)
  );

  sfwd_datapath #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .stValid    (stValid),
    .stReady    (stReady),
    .stAddr     (stAddr),
    .stSize     (stSize),
    .stData     (stData),
    .drainEn    (drainEn),
    .ldAddr     (ldAddr),
    .ldSize     (ldSize),
    .strb       (strb),
    .busyIn     (busy),
    .hit        (hit),
    .canFwd     (canFwd),
    .respValid  (ldRespValid),
    .respData   (ldRespData),
    .respFwd    (ldRespFwd),
    .blockPulse (ldFwdBlock),
    .blockCnt   (blockCount)
  );
endmodule

// File: tb/sfwd_unit_test.sv
module sfwd_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 3;
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic clk = 1'b0, rst = 1'b1;
  logic stValid = 0, stReady, drainEn = 0, ldValid = 0, ldReady;
  logic [7:0] stAddr = 0, ldAddr = 0;
  logic [1:0] stSize = 0, ldSize = 0;
  logic [255:0] stData = 0, ldRespData;
  logic ldRespValid, ldRespFwd, ldFwdBlock;
  logic [CW-1:0] blockCount;

  int checks = 0, failures = 0;
  bit finished = 0;
  logic [CW-1:0] expCnt = 0;

  logic [7:0]   refMem [256];
  logic [7:0]   qA[$];
  logic [1:0]   qS[$];
  logic [255:0] qD[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sfwd_unit #(.ADDR_W(8), .DEPTH(4), .CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .stValid(stValid), .stReady(stReady), .stAddr(stAddr),
    .stSize(stSize), .stData(stData), .drainEn(drainEn), .ldValid(ldValid),
    .ldReady(ldReady), .ldAddr(ldAddr), .ldSize(ldSize), .ldRespValid(ldRespValid),
    .ldRespData(ldRespData), .ldRespFwd(ldRespFwd), .ldFwdBlock(ldFwdBlock),
    .blockCount(blockCount));

  function automatic logic [255:0] pat(input logic [7:0] s);
    logic [255:0] d;
    for (int j = 0; j < 32; j++) d[8*j +: 8] = s + 8'(j * 3);
    return d;
  endfunction

  function automatic logic [255:0] msk(input logic [255:0] d, input logic [1:0] sz);
    for (int j = 0; j < 32; j++) if (j >= (8 << sz)) d[8*j +: 8] = 8'h00;
    return d;
  endfunction

  function automatic logic [255:0] memRead(input logic [7:0] a, input logic [1:0] sz);
    logic [255:0] d = '0;
    for (int j = 0; j < (8 << sz); j++) d[8*j +: 8] = refMem[a + 8'(j)];
    return d;
  endfunction

  task automatic check(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clearModel();
    for (int b = 0; b < 256; b++) refMem[b] = 8'h00;
    qA.delete(); qS.delete(); qD.delete();
  endtask

  task automatic doStore(input logic [7:0] a, input logic [1:0] sz, input logic [255:0] d);
    @(negedge clk);
    check(stReady, "R9 store ready", 256'(stReady), 256'(1));
    stValid = 1; stAddr = a; stSize = sz; stData = d;
    @(posedge clk); @(negedge clk);
    stValid = 0;
    qA.push_back(a); qS.push_back(sz); qD.push_back(d);
  endtask

  task automatic drainOne();
    drainEn = 1;
    @(posedge clk); @(negedge clk);
    drainEn = 0;
    if (qA.size() > 0) begin
      for (int j = 0; j < (8 << qS[0]); j++) refMem[qA[0] + 8'(j)] = qD[0][8*j +: 8];
      void'(qA.pop_front()); void'(qS.pop_front()); void'(qD.pop_front());
    end
  endtask

  // leaves the bench at the falling edge where the outcome is visible
  task automatic issueLoad(input logic [7:0] a, input logic [1:0] sz);
    @(negedge clk);
    ldValid = 1; ldAddr = a; ldSize = sz;
    @(posedge clk); @(negedge clk);
    ldValid = 0;
    // R12 readies drop while the load is outstanding
    check(!ldReady && !stReady, "R12 busy readies", {ldReady, stReady}, 256'(0));
    @(posedge clk); @(negedge clk);
  endtask

  task automatic expectFwd(input string req, input logic [255:0] exp);
    check(ldRespValid && ldRespFwd && !ldFwdBlock, {req, " forwarded"},
          {ldRespValid, ldRespFwd, ldFwdBlock}, 256'b110);
    check(ldRespData == exp, {req, " data"}, ldRespData, exp);
  endtask

  task automatic expectBlock(input string req);
    if (expCnt != CMAX) expCnt = expCnt + 1'b1;
    check(ldFwdBlock && !ldRespValid, {req, " block pulse"}, {ldFwdBlock, ldRespValid}, 256'b10);
    check(blockCount == expCnt, {req, " counter"}, 256'(blockCount), 256'(expCnt));
  endtask

  // drains until the model says the load is clear, then checks the memory reply
  task automatic finishBlocked(input string req, input logic [7:0] a, input logic [1:0] sz, input int nDrain);
    for (int n = 0; n < nDrain; n++) begin
      drainOne();
      check(!ldRespValid, {req, " R6 no early reply"}, 256'(ldRespValid), 256'(0));
    end
    @(posedge clk); @(negedge clk);
    check(ldRespValid && !ldRespFwd, "R6 reply after drain", {ldRespValid, ldRespFwd}, 256'b10);
    check(ldRespData == memRead(a, sz), "R6 merged data", ldRespData, memRead(a, sz));
    check(blockCount == expCnt, "R7 counted once", 256'(blockCount), 256'(expCnt));
  endtask

  task automatic testReset();
    @(negedge clk);
    check(stReady && ldReady && !ldRespValid && !ldFwdBlock, "R11 reset outputs",
          {stReady, ldReady, ldRespValid, ldFwdBlock}, 256'b1100);
    check(blockCount == 0, "R11 counter zero", 256'(blockCount), 256'(0));
    issueLoad(8'h40, 2'd2);
    check(ldRespValid && !ldRespFwd && ldRespData == 0, "R11 memory zero", ldRespData, 256'(0));
  endtask

  task automatic testSame16();
    doStore(8'h10, 2'd1, pat(8'h11));
    issueLoad(8'h10, 2'd1);
    expectFwd("R1", msk(pat(8'h11), 2'd1));
    check(blockCount == expCnt, "R1 counter", 256'(blockCount), 256'(expCnt));
    drainOne();
    doStore(8'h08, 2'd0, pat(8'h2A));
    issueLoad(8'h08, 2'd0);
    expectFwd("R1 8B", msk(pat(8'h2A), 2'd0));
    drainOne();
  endtask

  task automatic testHalves();
    logic [255:0] d = pat(8'h50);
    doStore(8'h20, 2'd2, d);
    issueLoad(8'h20, 2'd1);
    expectFwd("R2 low half", msk(d, 2'd1));
    issueLoad(8'h30, 2'd1);
    expectFwd("R2 high half", msk(d >> 128, 2'd1));
    drainOne();
  endtask

  task automatic testFull32();
    doStore(8'h40, 2'd2, pat(8'h70));
    issueLoad(8'h40, 2'd2);
    expectBlock("R3");
    repeat (3) begin
      @(posedge clk); @(negedge clk);
      check(!ldRespValid && !ldFwdBlock, "R7 quiet wait", {ldRespValid, ldFwdBlock}, 256'(0));
    end
    check(blockCount == expCnt, "R7 no recount", 256'(blockCount), 256'(expCnt));
    finishBlocked("R3", 8'h40, 2'd2, 1);
  endtask

  task automatic testMismatch();
    doStore(8'h60, 2'd2, pat(8'h90));
    drainOne();
    doStore(8'h70, 2'd1, pat(8'hC0));
    issueLoad(8'h60, 2'd2);
    expectBlock("R4 wide load");
    finishBlocked("R4", 8'h60, 2'd2, 1);
    doStore(8'h80, 2'd2, pat(8'h05));
    issueLoad(8'h88, 2'd0);
    expectBlock("R4 narrow load");
    finishBlocked("R4", 8'h88, 2'd0, 1);
  endtask

  task automatic testYoungest();
    doStore(8'hA0, 2'd2, pat(8'h33));
    doStore(8'hA0, 2'd1, pat(8'hE1));
    issueLoad(8'hA0, 2'd1);
    expectFwd("R5 youngest fwd", msk(pat(8'hE1), 2'd1));
    doStore(8'hB0, 2'd0, pat(8'h77));
    issueLoad(8'hB0, 2'd1);
    expectBlock("R5 youngest block");
    finishBlocked("R5", 8'hB0, 2'd1, 3);
  endtask

  task automatic testNoOverlap();
    doStore(8'h18, 2'd0, pat(8'hAB));
    issueLoad(8'h10, 2'd0);
    check(ldRespValid && !ldRespFwd && !ldFwdBlock, "R8 memory reply",
          {ldRespValid, ldRespFwd, ldFwdBlock}, 256'b100);
    check(ldRespData == memRead(8'h10, 2'd0), "R8 data", ldRespData, memRead(8'h10, 2'd0));
    check(blockCount == expCnt, "R8 counter", 256'(blockCount), 256'(expCnt));
    drainOne();
  endtask

  task automatic testFull();
    doStore(8'hC0, 2'd0, pat(8'h01));
    doStore(8'hC8, 2'd0, pat(8'h02));
    doStore(8'hD0, 2'd0, pat(8'h03));
    doStore(8'hD8, 2'd0, pat(8'h04));
    check(!stReady, "R9 full backpressure", 256'(stReady), 256'(0));
    stValid = 1; stAddr = 8'hC0; stSize = 2'd0; stData = pat(8'hFE);
    @(posedge clk); @(negedge clk);
    stValid = 0;
    repeat (4) drainOne();
    issueLoad(8'hC0, 2'd2);
    check(ldRespValid && !ldRespFwd, "R9 dropped store absent", {ldRespValid, ldRespFwd}, 256'b10);
    check(ldRespData == memRead(8'hC0, 2'd2), "R9 drain data", ldRespData, memRead(8'hC0, 2'd2));
    doStore(8'hE0, 2'd0, pat(8'h10));
    doStore(8'hE0, 2'd0, pat(8'h20));
    drainOne(); drainOne();
    issueLoad(8'hE0, 2'd0);
    check(ldRespData == msk(pat(8'h20), 2'd0), "R9 oldest first", ldRespData, msk(pat(8'h20), 2'd0));
  endtask

  task automatic testSaturate();
    for (int n = 0; n < 4; n++) begin
      doStore(8'h00, 2'd2, pat(8'(n)));
      issueLoad(8'h00, 2'd2);
      expectBlock("R10 saturate");
      finishBlocked("R10", 8'h00, 2'd2, 1);
    end
    check(blockCount == CMAX, "R10 held at max", 256'(blockCount), 256'(CMAX));
    @(negedge clk); rst = 1;
    @(posedge clk); @(negedge clk); rst = 0;
    clearModel(); expCnt = 0;
    check(blockCount == 0, "R10 reset clears", 256'(blockCount), 256'(0));
  endtask

  initial begin
    clearModel();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    testReset();
    testSame16();
    testHalves();
    testFull32();
    testMismatch();
    testYoungest();
    testNoOverlap();
    testFull();
    testSaturate();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule